// File: doc/BRIEF.md
# Timestamp Coincidence Matcher

This block pairs trigger events from two independently triggered acquisition sides, called head and tail. Each event arrives as a timestamp with a small tag on its own valid/ready stream. The block holds the events in a shallow buffer kept in time order. It waits until the buffer covers enough time that any partner of the earliest event must already be present. It then classifies that earliest event either as a coincidence, paired with an event from the other side, or as a single.

Events from the two sides may reach the block far apart in arrival order. A hold span, set by the user, decides how much time the buffer must cover before the earliest event is judged. A match window, also set by the user, decides how close in time two events must be to count as a pair. A flush input drains the buffer at the end of a run. Every result leaves through one registered output stream with backpressure.

Top module: `ts_coinc_matcher`

## Requirements
- R1: After reset, `out_valid` is 0 and, with `flush` low, `h_ready` is 1.
- R2: The buffer stays ordered by timestamp whatever the arrival order. Records come out in nondecreasing order of the earliest event's timestamp. Events with equal timestamps keep their arrival order.
- R3: The earliest event is judged only when the newest buffered timestamp minus the earliest is strictly greater than `span_cfg`. When the difference is equal to `span_cfg`, no record is emitted.
- R4: Two events match when the later timestamp minus the earlier is at most `win_cfg`, the limit included. A coincidence record has `out_coinc`=1 and carries the partner in `out_b_ts`/`out_b_tag`. A single has `out_coinc`=0.
- R5: Only a head event and a tail event can match. Two events from the same side are emitted as singles even when their timestamps fall inside the window. `out_a_side` is 0 for head and 1 for tail.
- R6: When several partners fall inside the window, the one closest in time is chosen. When two candidates are equally close, the one that arrived first is chosen.
- R7: An event already used as a partner is later removed without emitting any record.
- R8: The buffer holds 16 events. When it is full and a new event is offered, the earliest event is judged and emitted first, and only then is the new event accepted.
- R9: While `flush` is high, no input is accepted and every buffered event is judged in time order, regardless of the span.
- R10: While `out_valid` is 1 and `out_ready` is 0, the record is held unchanged.
- R11: When both sides offer an event in the same cycle, the head event is accepted and `t_ready` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| span_cfg | input | 16 | Hold span: the buffered time range that triggers a judgement |
| win_cfg | input | 16 | Match window, inclusive |
| flush | input | 1 | Drain every buffered event |
| h_valid | input | 1 | Head event offered |
| h_ready | output | 1 | Head event accepted |
| h_ts | input | 16 | Head timestamp |
| h_tag | input | 8 | Head event tag |
| t_valid | input | 1 | Tail event offered |
| t_ready | output | 1 | Tail event accepted |
| t_ts | input | 16 | Tail timestamp |
| t_tag | input | 8 | Tail event tag |
| out_ready | input | 1 | Consumer takes the record |
| out_valid | output | 1 | Record present |
| out_coinc | output | 1 | 1 for coincidence, 0 for single |
| out_a_side | output | 1 | Side of the earliest event (0 head, 1 tail) |
| out_a_ts | output | 16 | Timestamp of the earliest event |
| out_a_tag | output | 8 | Tag of the earliest event |
| out_b_ts | output | 16 | Partner timestamp (0 for a single) |
| out_b_tag | output | 8 | Partner tag (0 for a single) |

## Verification
Retirement and new arrival compete for the same cycle. Retirement has priority, so an arrival must wait. The bench provokes this in two ways. It offers a seventeenth event to a full buffer. It also offers events while `flush` is high. It judges the outcome by the input handshake staying low and by exactly one record appearing before the new event is taken.

A second collision happens when a record is ready to leave while the consumer is stalled. The bench holds `out_ready` low during a flush and watches the record stay frozen. It then releases `out_ready` and counts that the record is delivered only once.

// File: rtl/cm_pkg.sv
package cm_pkg;
  typedef enum logic {
    SIDE_HEAD = 1'b0,
    SIDE_TAIL = 1'b1
  } side_e;
endpackage

// File: rtl/cm_sorted_buf.sv
module cm_sorted_buf #(
  parameter int DEPTH = 16,
  parameter int TS_W  = 16,
  parameter int TAG_W = 8,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          ins_en,
  input  logic                          ins_side,
  input  logic [TS_W-1:0]               ins_ts,
  input  logic [TAG_W-1:0]              ins_tag,
  input  logic                          pop_en,
  input  logic                          mark_en,
  input  logic [IDX_W-1:0]              mark_idx,
  output logic [DEPTH-1:0]              vld_q,
  output logic [DEPTH-1:0]              side_q,
  output logic [DEPTH-1:0]              used_q,
  output logic [DEPTH-1:0][TS_W-1:0]    ts_q,
  output logic [DEPTH-1:0][TAG_W-1:0]   tag_q,
  output logic [CNT_W-1:0]              cnt_q
);
  logic [DEPTH-1:0]            vld_d, side_d, used_d, used_m;
  logic [DEPTH-1:0][TS_W-1:0]  ts_d;
  logic [DEPTH-1:0][TAG_W-1:0] tag_d;
  logic [CNT_W-1:0]            cnt_d;
  logic [CNT_W-1:0]            pos;
  logic                        upd;

  assign upd = ins_en | pop_en;

  // insertion point: after every entry not later than the newcomer
  always_comb begin
    pos = '0;
    for (int i = 0; i < DEPTH; i++)
      if (vld_q[i] && (ts_q[i] <= ins_ts)) pos = pos + CNT_W'(1);
  end

  always_comb begin
    used_m = used_q;
    if (mark_en) used_m[mark_idx] = 1'b1;
    vld_d  = vld_q;
    side_d = side_q;
    used_d = used_m;
    ts_d   = ts_q;
    tag_d  = tag_q;
    if (pop_en) begin
      for (int i = 0; i < DEPTH - 1; i++) begin
        vld_d[i]  = vld_q[i+1];
        side_d[i] = side_q[i+1];
        used_d[i] = used_m[i+1];
        ts_d[i]   = ts_q[i+1];
        tag_d[i]  = tag_q[i+1];
      end
      vld_d[DEPTH-1]  = 1'b0;
      used_d[DEPTH-1] = 1'b0;
    end else if (ins_en) begin
      for (int i = 0; i < DEPTH; i++) begin
        if (CNT_W'(i) == pos) begin
          vld_d[i]  = 1'b1;
          side_d[i] = ins_side;
          used_d[i] = 1'b0;
          ts_d[i]   = ins_ts;
          tag_d[i]  = ins_tag;
        end else if ((CNT_W'(i) > pos) && (i > 0)) begin
          vld_d[i]  = vld_q[i-1];
          side_d[i] = side_q[i-1];
          used_d[i] = used_m[i-1];
          ts_d[i]   = ts_q[i-1];
          tag_d[i]  = tag_q[i-1];
        end
      end
    end
    cnt_d = cnt_q + CNT_W'(ins_en & ~pop_en) - CNT_W'(pop_en & ~ins_en);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q  <= '0;
      used_q <= '0;
      cnt_q  <= '0;
    end else if (upd) begin
      vld_q  <= vld_d;
      used_q <= used_d;
      cnt_q  <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (upd) begin
      side_q <= side_d;
      ts_q   <= ts_d;
      tag_q  <= tag_d;
    end
  end

  assert_cnt_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(DEPTH));

  assert_no_push_full_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_en && cnt_q == CNT_W'(DEPTH)) |-> 1'b0);

  generate
    for (genvar g = 0; g < DEPTH - 1; g++) begin : g_ord
      assert_sorted_R2: assert property (@(posedge clk) disable iff (!rst_n)
        vld_q[g+1] |-> (vld_q[g] && (ts_q[g] <= ts_q[g+1])));
    end
  endgenerate
endmodule

// File: rtl/cm_match_sel.sv
module cm_match_sel #(
  parameter int DEPTH = 16,
  parameter int TS_W  = 16,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic [DEPTH-1:0]           vld,
  input  logic [DEPTH-1:0]           side,
  input  logic [DEPTH-1:0]           used,
  input  logic [DEPTH-1:0][TS_W-1:0] ts,
  input  logic [TS_W-1:0]            win,
  output logic                       hit,
  output logic [IDX_W-1:0]           hit_idx
);
  logic [DEPTH-1:0] cand;

  generate
    for (genvar g = 0; g < DEPTH; g++) begin : g_cand
      if (g == 0) begin : g_self
        assign cand[g] = 1'b0;
      end else begin : g_other
        assign cand[g] = vld[g] & ~used[g] & (side[g] != side[0]) &
                         ((ts[g] - ts[0]) <= win);
      end
    end
  endgenerate

  // lowest index wins: nearest in time, earliest arrival among ties
  always_comb begin
    hit     = 1'b0;
    hit_idx = '0;
    for (int i = DEPTH - 1; i > 0; i--)
      if (cand[i]) begin
        hit     = 1'b1;
        hit_idx = IDX_W'(i);
      end
  end
endmodule

// File: rtl/ts_coinc_matcher.sv
module ts_coinc_matcher #(
  parameter int DEPTH = 16,
  parameter int TS_W  = 16,
  parameter int TAG_W = 8,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [TS_W-1:0]  span_cfg,
  input  logic [TS_W-1:0]  win_cfg,
  input  logic             flush,
  input  logic             h_valid,
  output logic             h_ready,
  input  logic [TS_W-1:0]  h_ts,
  input  logic [TAG_W-1:0] h_tag,
  input  logic             t_valid,
  output logic             t_ready,
  input  logic [TS_W-1:0]  t_ts,
  input  logic [TAG_W-1:0] t_tag,
  input  logic             out_ready,
  output logic             out_valid,
  output logic             out_coinc,
  output logic             out_a_side,
  output logic [TS_W-1:0]  out_a_ts,
  output logic [TAG_W-1:0] out_a_tag,
  output logic [TS_W-1:0]  out_b_ts,
  output logic [TAG_W-1:0] out_b_tag
);
  import cm_pkg::*;

  logic [1:0] rst_sync_q;
  logic       rst_ni;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ni = rst_sync_q[1];

  logic [DEPTH-1:0]            vld_q, side_q, used_q;
  logic [DEPTH-1:0][TS_W-1:0]  ts_q;
  logic [DEPTH-1:0][TAG_W-1:0] tag_q;
  logic [CNT_W-1:0]            cnt_q, cnt_m1;
  logic [IDX_W-1:0]            last_idx, hit_idx;
  logic                        hit, full, span_over, need_ret, out_free;
  logic                        pop_en, emit, ins_ok, ins_en;
  side_e                       ins_side;
  logic [TS_W-1:0]             ins_ts;
  logic [TAG_W-1:0]            ins_tag;

  cm_sorted_buf #(.DEPTH(DEPTH), .TS_W(TS_W), .TAG_W(TAG_W)) i_buf (
    .clk(clk), .rst_n(rst_ni),
    .ins_en(ins_en), .ins_side(ins_side), .ins_ts(ins_ts), .ins_tag(ins_tag),
    .pop_en(pop_en), .mark_en(emit & hit), .mark_idx(hit_idx),
    .vld_q(vld_q), .side_q(side_q), .used_q(used_q),
    .ts_q(ts_q), .tag_q(tag_q), .cnt_q(cnt_q)
  );

  cm_match_sel #(.DEPTH(DEPTH), .TS_W(TS_W)) i_sel (
    .vld(vld_q), .side(side_q), .used(used_q), .ts(ts_q),
    .win(win_cfg), .hit(hit), .hit_idx(hit_idx)
  );

  // retirement control: retire beats arrival
  always_comb begin
    cnt_m1    = cnt_q - CNT_W'(1);
    last_idx  = cnt_m1[IDX_W-1:0];
    full      = (cnt_q == CNT_W'(DEPTH));
    span_over = (ts_q[last_idx] - ts_q[0]) > span_cfg;
    need_ret  = (cnt_q != '0) &&
                (span_over || flush || (full && (h_valid || t_valid)));
    out_free  = ~out_valid | out_ready;
    pop_en    = need_ret && (used_q[0] || out_free);
    emit      = need_ret && !used_q[0] && out_free;
    ins_ok    = !need_ret && !full && !flush;
    h_ready   = ins_ok;
    t_ready   = ins_ok && !h_valid;
    ins_en    = (h_valid && h_ready) || (t_valid && t_ready);
    ins_side  = (h_valid && h_ready) ? SIDE_HEAD : SIDE_TAIL;
    ins_ts    = (h_valid && h_ready) ? h_ts  : t_ts;
    ins_tag   = (h_valid && h_ready) ? h_tag : t_tag;
  end

  // output record register
  logic out_valid_d;
  always_comb out_valid_d = emit ? 1'b1 : (out_ready ? 1'b0 : out_valid);

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) out_valid <= 1'b0;
    else         out_valid <= out_valid_d;
  end

  always_ff @(posedge clk) begin
    if (emit) begin
      out_coinc  <= hit;
      out_a_side <= side_q[0];
      out_a_ts   <= ts_q[0];
      out_a_tag  <= tag_q[0];
      out_b_ts   <= hit ? ts_q[hit_idx]  : '0;
      out_b_tag  <= hit ? tag_q[hit_idx] : '0;
    end
  end

  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_ni)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_a_tag) &&
                                   $stable(out_a_ts) && $stable(out_coinc)));

  assert_window_R4: assert property (@(posedge clk) disable iff (!rst_ni)
    (out_valid && out_coinc) |-> ((out_b_ts >= out_a_ts) &&
                                  ((out_b_ts - out_a_ts) <= win_cfg)));

  assert_flush_block_R9: assert property (@(posedge clk) disable iff (!rst_ni)
    flush |-> (!h_ready && !t_ready));

  assert_head_first_R11: assert property (@(posedge clk) disable iff (!rst_ni)
    h_valid |-> !t_ready);

  assert_accept_grows_R8: assert property (@(posedge clk) disable iff (!rst_ni)
    (h_valid && h_ready) |=> (cnt_q == $past(cnt_q) + CNT_W'(1)));
endmodule

// File: tb/test_ts_coinc_matcher.sv
`timescale 1ns/1ps
module test_ts_coinc_matcher;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] span_cfg, win_cfg;
  logic        flush;
  logic        h_valid, t_valid, h_ready, t_ready;
  logic [15:0] h_ts, t_ts;
  logic [7:0]  h_tag, t_tag;
  logic        out_ready, out_valid, out_coinc, out_a_side;
  logic [15:0] out_a_ts, out_b_ts;
  logic [7:0]  out_a_tag, out_b_tag;

  int n_chk = 0;
  int n_bad = 0;
  int nrec  = 0;
  bit done  = 1'b0;
  bit       r_coinc [0:255];
  bit       r_side  [0:255];
  int       r_ats   [0:255];
  int       r_atag  [0:255];
  int       r_btag  [0:255];

  always #5 clk = ~clk;

  ts_coinc_matcher i_ts_coinc_matcher (
    .clk(clk), .rst_n(rst_n), .span_cfg(span_cfg), .win_cfg(win_cfg),
    .flush(flush), .h_valid(h_valid), .h_ready(h_ready), .h_ts(h_ts),
    .h_tag(h_tag), .t_valid(t_valid), .t_ready(t_ready), .t_ts(t_ts),
    .t_tag(t_tag), .out_ready(out_ready), .out_valid(out_valid),
    .out_coinc(out_coinc), .out_a_side(out_a_side), .out_a_ts(out_a_ts),
    .out_a_tag(out_a_tag), .out_b_ts(out_b_ts), .out_b_tag(out_b_tag)
  );

  // monitor: a record is taken when valid and ready meet
  always @(negedge clk) begin
    if (rst_n && out_valid && out_ready && nrec < 256) begin
      r_coinc[nrec] = out_coinc;
      r_side[nrec]  = out_a_side;
      r_ats[nrec]   = int'(out_a_ts);
      r_atag[nrec]  = int'(out_a_tag);
      r_btag[nrec]  = int'(out_b_tag);
      nrec++;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic chk_rec(input int idx, input bit coinc, input int atag,
                         input int btag, input string req);
    chk(nrec > idx, req, nrec, idx + 1);
    if (nrec > idx) begin
      chk(r_coinc[idx] == coinc, req, int'(r_coinc[idx]), int'(coinc));
      chk(r_atag[idx] == atag, req, r_atag[idx], atag);
      if (coinc) chk(r_btag[idx] == btag, req, r_btag[idx], btag);
    end
  endtask

  task automatic push(input bit side, input int ts, input int tag);
    @(negedge clk);
    if (!side) begin h_valid = 1'b1; h_ts = 16'(ts); h_tag = 8'(tag); end
    else       begin t_valid = 1'b1; t_ts = 16'(ts); t_tag = 8'(tag); end
    #1;
    while (!(side ? t_ready : h_ready)) begin @(negedge clk); #1; end
    @(posedge clk); #1;
    if (!side) h_valid = 1'b0; else t_valid = 1'b0;
  endtask

  task automatic do_flush(input string req);
    @(negedge clk);
    flush = 1'b1;
    #1;
    chk(!h_ready && !t_ready, req, int'(h_ready), 0);
    repeat (40) @(negedge clk);
    flush = 1'b0;
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      n_bad++;
      n_chk++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int b;
    rst_n = 1'b0; span_cfg = 16'd100; win_cfg = 16'd10; flush = 1'b0;
    h_valid = 1'b0; t_valid = 1'b0; h_ts = '0; t_ts = '0; h_tag = '0; t_tag = '0;
    out_ready = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #1;
    // R1: reset state
    chk(out_valid == 1'b0, "R1 out_valid", int'(out_valid), 0);
    chk(h_ready == 1'b1, "R1 h_ready", int'(h_ready), 1);

    // R3 / R4 / R7: inclusive window, span retirement, silent partner
    b = nrec;
    push(1'b0, 1000, 1);
    push(1'b1, 1010, 2);
    repeat (5) @(negedge clk);
    chk(nrec == b, "R3 no retire under span", nrec, b);
    push(1'b0, 1111, 3);
    repeat (6) @(negedge clk);
    chk(nrec == b + 1, "R7 partner retired silently", nrec, b + 1);
    chk_rec(b, 1'b1, 1, 2, "R4 inclusive window pair");
    do_flush("R9 inputs blocked");
    chk_rec(b + 1, 1'b0, 3, 0, "R9 flush drains last");
    chk(nrec == b + 2, "R9 flush count", nrec, b + 2);

    // R4: one past the window is single
    b = nrec;
    push(1'b0, 2000, 4);
    push(1'b1, 2011, 5);
    do_flush("R9 inputs blocked");
    chk_rec(b, 1'b0, 4, 0, "R4 outside window head");
    chk_rec(b + 1, 1'b0, 5, 0, "R4 outside window tail");

    // R5: same side never pairs
    b = nrec;
    push(1'b0, 3000, 6);
    push(1'b0, 3002, 7);
    do_flush("R9 inputs blocked");
    chk_rec(b, 1'b0, 6, 0, "R5 same side single");
    chk_rec(b + 1, 1'b0, 7, 0, "R5 same side single");

    // R6: closest candidate, out of order arrival
    b = nrec;
    push(1'b0, 4000, 8);
    push(1'b1, 4008, 9);
    push(1'b1, 4003, 10);
    do_flush("R9 inputs blocked");
    chk_rec(b, 1'b1, 8, 10, "R6 closest partner");
    chk_rec(b + 1, 1'b0, 9, 0, "R7 remaining single");
    chk(nrec == b + 2, "R7 count", nrec, b + 2);

    // R6: equal distance goes to earlier arrival
    b = nrec;
    push(1'b0, 5000, 11);
    push(1'b1, 5004, 12);
    push(1'b1, 5004, 13);
    do_flush("R9 inputs blocked");
    chk_rec(b, 1'b1, 11, 12, "R6 tie to earlier");
    chk_rec(b + 1, 1'b0, 13, 0, "R6 tie leftover");

    // R2: sorted release
    b = nrec;
    push(1'b1, 6050, 14);
    push(1'b0, 6000, 15);
    push(1'b1, 6020, 16);
    do_flush("R9 inputs blocked");
    chk_rec(b, 1'b0, 15, 0, "R2 order 1st");
    chk_rec(b + 1, 1'b0, 16, 0, "R2 order 2nd");
    chk_rec(b + 2, 1'b0, 14, 0, "R2 order 3rd");

    // R3: span equal is not exceeded
    b = nrec;
    push(1'b0, 8000, 45);
    push(1'b1, 8100, 46);
    repeat (5) @(negedge clk);
    chk(nrec == b, "R3 span equal holds", nrec, b);
    push(1'b0, 8101, 47);
    repeat (5) @(negedge clk);
    chk(nrec == b + 1, "R3 span exceeded", nrec, b + 1);
    chk_rec(b, 1'b0, 45, 0, "R3 retired head");
    do_flush("R9 inputs blocked");
    chk_rec(b + 1, 1'b1, 46, 47, "R4 pair after retire");
    chk(nrec == b + 2, "R7 count", nrec, b + 2);

    // R8: full buffer forces the earliest out
    span_cfg = 16'd60000;
    b = nrec;
    for (int i = 0; i < 16; i++) push(1'b0, 7000 + 10 * i, 20 + i);
    repeat (3) @(negedge clk);
    chk(nrec == b, "R8 sixteen held", nrec, b);
    push(1'b0, 7500, 40);
    repeat (3) @(negedge clk);
    chk(nrec == b + 1, "R8 forced one out", nrec, b + 1);
    chk_rec(b, 1'b0, 20, 0, "R8 earliest forced");
    do_flush("R9 inputs blocked");
    chk(nrec == b + 17, "R8 drain count", nrec, b + 17);
    for (int i = 1; i < 16; i++)
      chk_rec(b + i, 1'b0, 20 + i, 0, "R9 drain order");
    chk_rec(b + 16, 1'b0, 40, 0, "R9 drain last");
    span_cfg = 16'd100;

    // R10: backpressure hold
    b = nrec;
    @(negedge clk);
    out_ready = 1'b0;
    push(1'b0, 9000, 50);
    @(negedge clk);
    flush = 1'b1;
    repeat (3) @(negedge clk);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk(out_valid && out_a_tag == 8'd50, "R10 held", int'(out_a_tag), 50);
    end
    flush = 1'b0;
    out_ready = 1'b1;
    repeat (4) @(negedge clk);
    chk(nrec == b + 1, "R10 delivered once", nrec, b + 1);
    chk_rec(b, 1'b0, 50, 0, "R10 record");

    // R11: head first when both offer
    b = nrec;
    @(negedge clk);
    h_valid = 1'b1; h_ts = 16'd9500; h_tag = 8'd60;
    t_valid = 1'b1; t_ts = 16'd9400; t_tag = 8'd61;
    #1;
    chk(h_ready && !t_ready, "R11 head priority", int'(t_ready), 0);
    @(posedge clk); #1;
    h_valid = 1'b0;
    @(negedge clk); #1;
    while (!t_ready) begin @(negedge clk); #1; end
    @(posedge clk); #1;
    t_valid = 1'b0;
    do_flush("R9 inputs blocked");
    chk_rec(b, 1'b0, 61, 0, "R11 tail earlier in time");
    chk_rec(b + 1, 1'b0, 60, 0, "R11 head later");

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule